// File: doc/BRIEF.md
# Dual-Channel Pointer-Indexed Register File

This block is the register front end of a two-channel serial controller. A host reaches it over one byte bus. A channel select picks channel A or B, and a port select picks the control port or the data port. On the control port, register 0 is always written directly. Every other register is reached in two steps. A write to register 0 loads a register pointer. The next control access, read or write, goes to the register named by that pointer. The pointer then falls back to 0. The data port bypasses the pointer and reaches the transmit and receive data bytes at once.

The block stores the write registers of both channels. The vector register (2) and the master control register (9) exist once and are shared by both channels. Register 7 has an alternate option register at the same address, and bit 0 of register 15 chooses between the two. Command fields are decoded into one-cycle code outputs and are never stored: the command and CRC fields of register 0, the recovery-loop field of register 14, and the reset field of register 9. The block also assembles the read registers from status supplied by the serial engines. This covers the interrupt-pending byte, which only channel A returns, the vector with the interrupt code folded in on channel B, and an extended mode that mirrors some write registers onto read addresses.

Top module: `dual_ptr_regfile`

## Requirements
- R1: After reset every stored register and both pointers are zero, `rdata` is zero, and every code output is zero.
- R2: A control write while the channel's pointer is 0 loads the pointer from bits 2:0, plus 8 when bits 5:3 are 001. The next control access on that channel reaches the pointed register, and then the pointer returns to 0. Each channel has its own pointer.
- R3: In a register 0 write, a value in bits 5:3 other than 000 and 001 appears on that channel's `cmd_code`, and bits 7:6 appear on `crc_code`. Both are valid for exactly the one cycle after the write edge, and 001 is never reported.
- R4: A write to register 7 stores into register 7 when bit 0 of register 15 is 0, and into the alternate option register (slot 8 of `wreg_q`) when that bit is 1.
- R5: Registers 2 and 9 are shared. A write through either channel shows up in both channels' slots of `wreg_q`.
- R6: Bits 7:6 of a register 9 write are a reset code and are never stored: 01 resets channel A, 10 resets channel B, 11 resets everything. The code appears on `rst_cmd` for one cycle after the write.
- R7: A channel reset clears that channel's private registers and its pointer at the write edge. The other channel and the shared registers are kept, even when the reset is written through the other channel's port.
- R8: A full reset clears every stored register, including the shared ones, and both pointers.
- R9: A register 14 write stores only bits 4:0. Bits 7:5 appear on `pll_code` for one cycle.
- R10: Read register 3 on channel A returns `{2'b00, irq_pend_in}`. On channel B it returns 0.
- R11: Read register 2 returns the shared vector on channel A. On channel B it returns `{vector[7:4], vec_code_in, vector[0]}`.
- R12: When bit 6 of the channel's alternate option register is 1, read registers 4, 5, 9 and 11 return write registers 4, 5, 3 and 10. Otherwise they return 0.
- R13: A data-port write, or a pointed write to register 8, pulses the channel's `tx_stb` bit and loads `tx_byte`. A data-port read returns that channel's `rx_byte_in`. The data port leaves the pointer untouched.
- R14: Read data is registered and changes only at the edge after a read strobe. When `wr_en` and `rd_en` are high together, the write is carried out and the read is dropped, so `rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_sel | input | 1 | Channel select, 0 = A, 1 = B |
| port_sel | input | 1 | Port select, 0 = control, 1 = data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| stat0_in | input | 2x8 | Read register 0 status per channel |
| stat1_in | input | 2x8 | Read register 1 status per channel |
| stat10_in | input | 2x8 | Read register 10 status per channel |
| rx_byte_in | input | 2x8 | Received byte per channel |
| irq_pend_in | input | 6 | Pending flags: bits 2:0 channel B ext/tx/rx, bits 5:3 channel A |
| vec_code_in | input | 3 | Current interrupt code folded into the channel B vector |
| rdata | output | 8 | Registered read data |
| wreg_q | output | 2x16x8 | Stored write registers per channel; slot 8 is the alternate option register |
| cmd_code | output | 2x3 | One-cycle register 0 command code per channel |
| crc_code | output | 2x2 | One-cycle CRC command per channel |
| pll_code | output | 2x3 | One-cycle recovery-loop command per channel |
| tx_stb | output | 2 | One-cycle transmit-byte strobe per channel |
| tx_byte | output | 8 | Last byte written for transmission |
| rst_cmd | output | 2 | One-cycle reset code from register 9 |

## Verification
The risky overlap is a register 9 reset and a pointed access landing on the same edge. When channel B's pointed access writes a channel A reset, that edge must return B's pointer to 0, clear A's registers and A's pending pointer, and leave the shared registers untouched. The bench sets up a pending pointer on channel A first, then issues the reset through channel B, and checks that a later channel A control read returns status rather than the pointed register. The second overlap is a read strobe and a write strobe in the same cycle. The bench judges it by `rdata` holding its previous value while the pointed register takes the new byte and the pointer returns to 0.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned PTR_BITS = 4;
   localparam int unsigned REG_CNT  = 1 << PTR_BITS;

   typedef enum logic [1:0] {
      RST_NONE   = 2'b00,
      RST_CHAN_A = 2'b01,
      RST_CHAN_B = 2'b10,
      RST_FULL   = 2'b11
   } rst_cmd_e;

   localparam logic [2:0] CMD_NULL       = 3'b000;
   localparam logic [2:0] CMD_POINT_HIGH = 3'b001;

   localparam logic [3:0] IDX_ZERO  = 4'd0;
   localparam logic [3:0] IDX_STAT1 = 4'd1;
   localparam logic [3:0] IDX_VEC   = 4'd2;
   localparam logic [3:0] IDX_IRQ   = 4'd3;
   localparam logic [3:0] IDX_R4    = 4'd4;
   localparam logic [3:0] IDX_R5    = 4'd5;
   localparam logic [3:0] IDX_SYNC  = 4'd7;
   localparam logic [3:0] IDX_TXD   = 4'd8;
   localparam logic [3:0] IDX_MIC   = 4'd9;
   localparam logic [3:0] IDX_R10   = 4'd10;
   localparam logic [3:0] IDX_R11   = 4'd11;
   localparam logic [3:0] IDX_R12   = 4'd12;
   localparam logic [3:0] IDX_R13   = 4'd13;
   localparam logic [3:0] IDX_PLL   = 4'd14;
   localparam logic [3:0] IDX_ICTL  = 4'd15;

   localparam int unsigned ALT_SLOT = 8;
   localparam int unsigned EXT_BIT  = 6;

endpackage

// File: rtl/dpr_decode.sv
module dpr_decode
   import dpr_pkg::*;
#(
   parameter int unsigned PTR_W = PTR_BITS
) (
   input  logic             ch_sel,
   input  logic             port_sel,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       mic_cmd,
   input  logic [PTR_W-1:0] ptr_a,
   input  logic [PTR_W-1:0] ptr_b,
   output logic [PTR_W-1:0] sel_ptr,
   output logic             rd_go,
   output logic             ctl_wr0,
   output logic             ptd_wr,
   output logic             ptd_rd,
   output logic             dat_wr,
   output logic [1:0]       chan_clr,
   output logic             full_clr,
   output rst_cmd_e         rst_code
);

   logic ptr_zero;
   logic mic_wr;

   always_comb begin
      sel_ptr  = ch_sel ? ptr_b : ptr_a;
      ptr_zero = (sel_ptr == '0);
      rd_go    = rd_en & ~wr_en;
      ctl_wr0  = wr_en & ~port_sel & ptr_zero;
      ptd_wr   = wr_en & ~port_sel & ~ptr_zero;
      ptd_rd   = rd_go & ~port_sel & ~ptr_zero;
      dat_wr   = wr_en & port_sel;
      mic_wr   = ptd_wr & (sel_ptr == PTR_W'(IDX_MIC));
      rst_code = mic_wr ? rst_cmd_e'(mic_cmd) : RST_NONE;
      full_clr = (rst_code == RST_FULL);
      chan_clr[0] = (rst_code == RST_CHAN_A) | full_clr;
      chan_clr[1] = (rst_code == RST_CHAN_B) | full_clr;
   end

endmodule

// File: rtl/dpr_chan.sv
module dpr_chan
   import dpr_pkg::*;
#(
   parameter int unsigned DATA_W = BYTE_W,
   parameter int unsigned PTR_W  = PTR_BITS,
   localparam int unsigned NREG  = 1 << PTR_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       sel,
   input  logic                       ctl_wr0,
   input  logic                       ptd_wr,
   input  logic                       ptd_rd,
   input  logic                       dat_wr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [PTR_W-1:0]           ptr_q,
   output logic [NREG-1:0][DATA_W-1:0] regs_q,
   output logic [2:0]                 cmd_q,
   output logic [1:0]                 crc_q,
   output logic [2:0]                 pll_q,
   output logic                       tx_q
);

   logic       alt_sel;
   logic [2:0] wr0_cmd;

   assign alt_sel = regs_q[IDX_ICTL][0];
   assign wr0_cmd = wdata[5:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         regs_q <= '0;
         cmd_q  <= '0;
         crc_q  <= '0;
         pll_q  <= '0;
         tx_q   <= 1'b0;
      end else begin
         cmd_q <= '0;
         crc_q <= '0;
         pll_q <= '0;
         tx_q  <= 1'b0;
         if (clr) begin
            regs_q <= '0;
            ptr_q  <= '0;
         end else if (sel) begin
            if (ctl_wr0) begin
               ptr_q <= {(wr0_cmd == CMD_POINT_HIGH), wdata[2:0]};
               if (wr0_cmd != CMD_NULL && wr0_cmd != CMD_POINT_HIGH) begin
                  cmd_q <= wr0_cmd;
               end
               crc_q <= wdata[7:6];
            end
            if (ptd_wr || ptd_rd) begin
               ptr_q <= '0;
            end
            if (ptd_wr) begin
               case (ptr_q)
                  IDX_SYNC: begin
                     if (alt_sel) regs_q[ALT_SLOT] <= wdata;
                     else         regs_q[IDX_SYNC] <= wdata;
                  end
                  IDX_PLL: begin
                     regs_q[IDX_PLL] <= {3'b000, wdata[4:0]};
                     pll_q           <= wdata[7:5];
                  end
                  IDX_TXD:  tx_q <= 1'b1;
                  IDX_VEC:  ;
                  IDX_MIC:  ;
                  default:  regs_q[ptr_q] <= wdata;
               endcase
            end
            if (dat_wr) begin
               tx_q <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dpr_shared.sv
module dpr_shared
   import dpr_pkg::*;
#(
   parameter int unsigned DATA_W = BYTE_W,
   parameter int unsigned PTR_W  = PTR_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_clr,
   input  logic              ptd_wr,
   input  logic [PTR_W-1:0]  sel_ptr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] vec_q,
   output logic [DATA_W-1:0] mic_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
         mic_q <= '0;
      end else if (full_clr) begin
         vec_q <= '0;
         mic_q <= '0;
      end else if (ptd_wr) begin
         if (sel_ptr == PTR_W'(IDX_VEC)) begin
            vec_q <= wdata;
         end
         if (sel_ptr == PTR_W'(IDX_MIC)) begin
            mic_q <= {2'b00, wdata[DATA_W-3:0]};
         end
      end
   end

endmodule

// File: rtl/dpr_rdmux.sv
module dpr_rdmux
   import dpr_pkg::*;
#(
   parameter int unsigned DATA_W = BYTE_W,
   parameter int unsigned PTR_W  = PTR_BITS
) (
   input  logic                   ch_sel,
   input  logic                   port_sel,
   input  logic [PTR_W-1:0]       sel_ptr,
   input  logic                   ext_rd,
   input  logic [DATA_W-1:0]      w3,
   input  logic [DATA_W-1:0]      w4,
   input  logic [DATA_W-1:0]      w5,
   input  logic [DATA_W-1:0]      w10,
   input  logic [DATA_W-1:0]      w12,
   input  logic [DATA_W-1:0]      w13,
   input  logic [DATA_W-1:0]      w15,
   input  logic [DATA_W-1:0]      vec_q,
   input  logic [1:0][DATA_W-1:0] stat0_in,
   input  logic [1:0][DATA_W-1:0] stat1_in,
   input  logic [1:0][DATA_W-1:0] stat10_in,
   input  logic [1:0][DATA_W-1:0] rx_byte_in,
   input  logic [5:0]             irq_pend_in,
   input  logic [2:0]             vec_code_in,
   output logic [DATA_W-1:0]      rd_val
);

   always_comb begin
      rd_val = '0;
      if (port_sel) begin
         rd_val = rx_byte_in[ch_sel];
      end else begin
         case (sel_ptr)
            IDX_ZERO:  rd_val = stat0_in[ch_sel];
            IDX_STAT1: rd_val = stat1_in[ch_sel];
            IDX_VEC:   rd_val = ch_sel ? {vec_q[7:4], vec_code_in, vec_q[0]} : vec_q;
            IDX_IRQ:   rd_val = ch_sel ? '0 : {2'b00, irq_pend_in};
            IDX_R4:    rd_val = ext_rd ? w4 : '0;
            IDX_R5:    rd_val = ext_rd ? w5 : '0;
            IDX_TXD:   rd_val = rx_byte_in[ch_sel];
            IDX_MIC:   rd_val = ext_rd ? w3 : '0;
            IDX_R10:   rd_val = stat10_in[ch_sel];
            IDX_R11:   rd_val = ext_rd ? w10 : '0;
            IDX_R12:   rd_val = w12;
            IDX_R13:   rd_val = w13;
            IDX_ICTL:  rd_val = w15;
            default:   rd_val = '0;
         endcase
      end
   end

endmodule

// File: rtl/dual_ptr_regfile.sv
module dual_ptr_regfile
   import dpr_pkg::*;
#(
   parameter int unsigned DATA_W   = BYTE_W,
   parameter int unsigned PTR_W    = PTR_BITS,
   parameter bit          READ_REG = 1'b1,
   localparam int unsigned NREG    = 1 << PTR_W,
   localparam int unsigned NCH     = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ch_sel,
   input  logic                             port_sel,
   input  logic                             wr_en,
   input  logic                             rd_en,
   input  logic [DATA_W-1:0]                wdata,
   input  logic [NCH-1:0][DATA_W-1:0]       stat0_in,
   input  logic [NCH-1:0][DATA_W-1:0]       stat1_in,
   input  logic [NCH-1:0][DATA_W-1:0]       stat10_in,
   input  logic [NCH-1:0][DATA_W-1:0]       rx_byte_in,
   input  logic [5:0]                       irq_pend_in,
   input  logic [2:0]                       vec_code_in,
   output logic [DATA_W-1:0]                rdata,
   output logic [NCH-1:0][NREG-1:0][DATA_W-1:0] wreg_q,
   output logic [NCH-1:0][2:0]              cmd_code,
   output logic [NCH-1:0][1:0]              crc_code,
   output logic [NCH-1:0][2:0]              pll_code,
   output logic [NCH-1:0]                   tx_stb,
   output logic [DATA_W-1:0]                tx_byte,
   output logic [1:0]                       rst_cmd
);

   if (DATA_W != 8) begin : g_bad_width
      $error("dual_ptr_regfile: DATA_W must be 8");
   end
   if (PTR_W != 4) begin : g_bad_ptr
      $error("dual_ptr_regfile: PTR_W must be 4");
   end

   logic [NCH-1:0][PTR_W-1:0]           ptr_arr;
   logic [NCH-1:0][NREG-1:0][DATA_W-1:0] chan_regs;
   logic [NREG-1:0][DATA_W-1:0]         cur_regs;
   logic [PTR_W-1:0]                    sel_ptr;
   logic                                rd_go, ctl_wr0, ptd_wr, ptd_rd, dat_wr, full_clr;
   logic [NCH-1:0]                      chan_clr;
   rst_cmd_e                            rst_code;
   logic [DATA_W-1:0]                   vec_q, mic_q, rd_val;

   dpr_decode #(.PTR_W(PTR_W)) u_decode (
      .ch_sel   (ch_sel),
      .port_sel (port_sel),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .mic_cmd  (wdata[DATA_W-1:DATA_W-2]),
      .ptr_a    (ptr_arr[0]),
      .ptr_b    (ptr_arr[1]),
      .sel_ptr  (sel_ptr),
      .rd_go    (rd_go),
      .ctl_wr0  (ctl_wr0),
      .ptd_wr   (ptd_wr),
      .ptd_rd   (ptd_rd),
      .dat_wr   (dat_wr),
      .chan_clr (chan_clr),
      .full_clr (full_clr),
      .rst_code (rst_code)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      localparam logic CH_ID = 1'(c);
      dpr_chan #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (chan_clr[c]),
         .sel     (ch_sel == CH_ID),
         .ctl_wr0 (ctl_wr0),
         .ptd_wr  (ptd_wr),
         .ptd_rd  (ptd_rd),
         .dat_wr  (dat_wr),
         .wdata   (wdata),
         .ptr_q   (ptr_arr[c]),
         .regs_q  (chan_regs[c]),
         .cmd_q   (cmd_code[c]),
         .crc_q   (crc_code[c]),
         .pll_q   (pll_code[c]),
         .tx_q    (tx_stb[c])
      );

      always_comb begin
         wreg_q[c]          = chan_regs[c];
         wreg_q[c][IDX_VEC] = vec_q;
         wreg_q[c][IDX_MIC] = mic_q;
      end
   end

   dpr_shared #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_shared (
      .clk      (clk),
      .rst_n    (rst_n),
      .full_clr (full_clr),
      .ptd_wr   (ptd_wr),
      .sel_ptr  (sel_ptr),
      .wdata    (wdata),
      .vec_q    (vec_q),
      .mic_q    (mic_q)
   );

   assign cur_regs = chan_regs[ch_sel];

   dpr_rdmux #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_rdmux (
      .ch_sel      (ch_sel),
      .port_sel    (port_sel),
      .sel_ptr     (sel_ptr),
      .ext_rd      (cur_regs[ALT_SLOT][EXT_BIT]),
      .w3          (cur_regs[IDX_IRQ]),
      .w4          (cur_regs[IDX_R4]),
      .w5          (cur_regs[IDX_R5]),
      .w10         (cur_regs[IDX_R10]),
      .w12         (cur_regs[IDX_R12]),
      .w13         (cur_regs[IDX_R13]),
      .w15         (cur_regs[IDX_ICTL]),
      .vec_q       (vec_q),
      .stat0_in    (stat0_in),
      .stat1_in    (stat1_in),
      .stat10_in   (stat10_in),
      .rx_byte_in  (rx_byte_in),
      .irq_pend_in (irq_pend_in),
      .vec_code_in (vec_code_in),
      .rd_val      (rd_val)
   );

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata <= '0;
         else if (rd_go) rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign rdata = rd_go ? rd_val : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_byte <= '0;
         rst_cmd <= '0;
      end else begin
         rst_cmd <= rst_code;
         if (dat_wr || (ptd_wr && sel_ptr == PTR_W'(IDX_TXD))) begin
            tx_byte <= wdata;
         end
      end
   end

endmodule

// File: rtl/dual_ptr_regfile_chk.sv
module dual_ptr_regfile_chk #(
   parameter bit READ_REG = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ch_sel,
   input logic                  port_sel,
   input logic                  wr_en,
   input logic                  rd_en,
   input logic [7:0]            rdata,
   input logic [1:0][15:0][7:0] wreg_q,
   input logic [1:0][2:0]       cmd_code,
   input logic [1:0]            tx_stb,
   input logic [1:0]            rst_cmd,
   input logic [1:0][3:0]       ptr_q
);

   logic [3:0] cur_ptr;
   assign cur_ptr = ch_sel ? ptr_q[1] : ptr_q[0];

   AST_PTR_RETURN_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_sel && !port_sel && (wr_en || rd_en) && cur_ptr != 4'd0) |=> (ptr_q[0] == 4'd0)); // R2

   AST_CMD_FROM_WR0_A: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code[0] != 3'd0) |-> $past(wr_en && !ch_sel && !port_sel)); // R3

   AST_CMD_FROM_WR0_B: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code[1] != 3'd0) |-> $past(wr_en && ch_sel && !port_sel)); // R3

   AST_MIC_NO_CMD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (wreg_q[0][9][7:6] == 2'b00)); // R6

   AST_CHAN_A_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_cmd == 2'b01) |-> (ptr_q[0] == 4'd0 && wreg_q[0][15] == 8'd0)); // R7

   AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_cmd == 2'b11) |-> (wreg_q == '0 && ptr_q == '0)); // R8

   AST_PLL_CMD_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wreg_q[0][14][7:5] == 3'd0 && wreg_q[1][14][7:5] == 3'd0)); // R9

   AST_TX_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_stb)); // R13

   if (READ_REG) begin : g_hold
      AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_en || wr_en) |=> $stable(rdata)); // R14
   end

endmodule

bind dual_ptr_regfile dual_ptr_regfile_chk #(.READ_REG(READ_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ch_sel   (ch_sel),
   .port_sel (port_sel),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rdata    (rdata),
   .wreg_q   (wreg_q),
   .cmd_code (cmd_code),
   .tx_stb   (tx_stb),
   .rst_cmd  (rst_cmd),
   .ptr_q    (ptr_arr)
);

// File: tb/dual_ptr_regfile_bench.sv
module dual_ptr_regfile_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic CHA = 1'b0;
   localparam logic CHB = 1'b1;
   localparam logic CTL = 1'b0;
   localparam logic DAT = 1'b1;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  ch_sel = 1'b0, port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]            wdata = '0;
   logic [1:0][7:0]       stat0_in, stat1_in, stat10_in, rx_byte_in;
   logic [5:0]            irq_pend_in;
   logic [2:0]            vec_code_in;
   logic [7:0]            rdata;
   logic [1:0][15:0][7:0] wreg_q;
   logic [1:0][2:0]       cmd_code;
   logic [1:0][1:0]       crc_code;
   logic [1:0][2:0]       pll_code;
   logic [1:0]            tx_stb;
   logic [7:0]            tx_byte;
   logic [1:0]            rst_cmd;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_ptr_regfile u_dual_ptr_regfile (
      .clk (clk), .rst_n (rst_n), .ch_sel (ch_sel), .port_sel (port_sel),
      .wr_en (wr_en), .rd_en (rd_en), .wdata (wdata),
      .stat0_in (stat0_in), .stat1_in (stat1_in), .stat10_in (stat10_in),
      .rx_byte_in (rx_byte_in), .irq_pend_in (irq_pend_in), .vec_code_in (vec_code_in),
      .rdata (rdata), .wreg_q (wreg_q), .cmd_code (cmd_code), .crc_code (crc_code),
      .pll_code (pll_code), .tx_stb (tx_stb), .tx_byte (tx_byte), .rst_cmd (rst_cmd)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic ch, input logic prt, input logic [7:0] d);
      @(negedge clk);
      ch_sel = ch; port_sel = prt; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic ch, input logic prt, output logic [7:0] d);
      @(negedge clk);
      ch_sel = ch; port_sel = prt; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic set_ptr(input logic ch, input logic [3:0] idx);
      bus_wr(ch, CTL, {2'b00, (idx[3] ? 3'b001 : 3'b000), idx[2:0]});
   endtask

   task automatic reg_wr(input logic ch, input logic [3:0] idx, input logic [7:0] d);
      set_ptr(ch, idx);
      bus_wr(ch, CTL, d);
   endtask

   task automatic reg_rd(input logic ch, input logic [3:0] idx, output logic [7:0] d);
      set_ptr(ch, idx);
      bus_rd(ch, CTL, d);
   endtask

   task automatic t_reset;
      chk("R1 rdata", rdata, 8'h00);
      chk("R1 wreg_q", {7'b0, |wreg_q}, 8'h00);
      chk("R1 codes", {2'b0, |cmd_code, |crc_code, |pll_code, |tx_stb, |rst_cmd, |tx_byte}, 8'h00);
   endtask

   task automatic t_pointer;
      logic [7:0] d;
      reg_wr(CHA, 4'd12, 8'h3C);
      chk("R2 pointed write", wreg_q[0][12], 8'h3C);
      bus_rd(CHA, CTL, d);
      chk("R2 pointer back to 0", d, 8'hA1);
      reg_wr(CHA, 4'd13, 8'h77);
      chk("R2 point high", wreg_q[0][13], 8'h77);
      chk("R2 low slot untouched", wreg_q[0][5], 8'h00);
      set_ptr(CHA, 4'd12);
      bus_rd(CHB, CTL, d);
      chk("R2 channel B pointer separate", d, 8'hB1);
      bus_rd(CHA, CTL, d);
      chk("R2 channel A pointed read", d, 8'h3C);
   endtask

   task automatic t_wr0_cmd;
      logic [7:0] d;
      bus_wr(CHB, CTL, 8'b10_010_000);
      chk("R3 cmd_code B", {5'b0, cmd_code[1]}, 8'h02);
      chk("R3 crc_code B", {6'b0, crc_code[1]}, 8'h02);
      chk("R3 cmd_code A quiet", {5'b0, cmd_code[0]}, 8'h00);
      @(negedge clk);
      chk("R3 one cycle", {5'b0, cmd_code[1]}, 8'h00);
      bus_wr(CHA, CTL, 8'h08);
      chk("R3 point high not a command", {5'b0, cmd_code[0]}, 8'h00);
      bus_rd(CHA, CTL, d);
      chk("R2 pointed read of 8", d, 8'hA4);
   endtask

   task automatic t_alias;
      reg_wr(CHA, 4'd15, 8'h00);
      reg_wr(CHA, 4'd7, 8'h7E);
      chk("R4 primary", wreg_q[0][7], 8'h7E);
      chk("R4 alternate idle", wreg_q[0][8], 8'h00);
      reg_wr(CHA, 4'd15, 8'h01);
      reg_wr(CHA, 4'd7, 8'h42);
      chk("R4 alternate", wreg_q[0][8], 8'h42);
      chk("R4 primary kept", wreg_q[0][7], 8'h7E);
   endtask

   task automatic t_shared;
      logic [7:0] d;
      reg_wr(CHA, 4'd2, 8'h95);
      chk("R5 vector in B", wreg_q[1][2], 8'h95);
      reg_wr(CHB, 4'd9, 8'h2B);
      chk("R5 master in A", wreg_q[0][9], 8'h2B);
      reg_rd(CHA, 4'd2, d);
      chk("R11 vector plain on A", d, 8'h95);
      reg_rd(CHB, 4'd2, d);
      chk("R11 vector folded on B", d, 8'h9D);
   endtask

   task automatic t_irq;
      logic [7:0] d;
      reg_rd(CHA, 4'd3, d);
      chk("R10 pending on A", d, 8'h2D);
      reg_rd(CHB, 4'd3, d);
      chk("R10 zero on B", d, 8'h00);
   endtask

   task automatic t_ext;
      logic [7:0] d;
      reg_wr(CHB, 4'd4, 8'h14);
      reg_wr(CHB, 4'd5, 8'h15);
      reg_wr(CHB, 4'd3, 8'h13);
      reg_wr(CHB, 4'd10, 8'h1A);
      reg_rd(CHB, 4'd4, d);
      chk("R12 mirror off", d, 8'h00);
      reg_rd(CHB, 4'd9, d);
      chk("R12 mirror off 9", d, 8'h00);
      reg_wr(CHB, 4'd15, 8'h01);
      reg_wr(CHB, 4'd7, 8'h40);
      reg_rd(CHB, 4'd4, d);
      chk("R12 read 4", d, 8'h14);
      reg_rd(CHB, 4'd5, d);
      chk("R12 read 5", d, 8'h15);
      reg_rd(CHB, 4'd9, d);
      chk("R12 read 9", d, 8'h13);
      reg_rd(CHB, 4'd11, d);
      chk("R12 read 11", d, 8'h1A);
      reg_rd(CHB, 4'd10, d);
      chk("R12 status 10 unaffected", d, 8'hB3);
   endtask

   task automatic t_pll;
      reg_wr(CHA, 4'd14, 8'hFF);
      chk("R9 pll_code", {5'b0, pll_code[0]}, 8'h07);
      chk("R9 stored low bits", wreg_q[0][14], 8'h1F);
   endtask

   task automatic t_data;
      logic [7:0] d;
      set_ptr(CHA, 4'd12);
      bus_wr(CHA, DAT, 8'hC3);
      chk("R13 tx_stb A", {6'b0, tx_stb}, 8'h01);
      chk("R13 tx_byte", tx_byte, 8'hC3);
      bus_rd(CHA, DAT, d);
      chk("R13 data read", d, 8'hA4);
      bus_rd(CHA, CTL, d);
      chk("R13 pointer kept", d, 8'h3C);
      reg_wr(CHB, 4'd8, 8'h5D);
      chk("R13 tx_stb B via pointer", {6'b0, tx_stb}, 8'h02);
      chk("R13 tx_byte B", tx_byte, 8'h5D);
   endtask

   task automatic t_chan_reset;
      logic [7:0] d;
      set_ptr(CHA, 4'd12);
      reg_wr(CHB, 4'd9, 8'h45);
      chk("R6 rst_cmd A", {6'b0, rst_cmd}, 8'h01);
      chk("R6 code bits not stored", wreg_q[0][9], 8'h05);
      chk("R7 A cleared 12", wreg_q[0][12], 8'h00);
      chk("R7 A cleared 15", wreg_q[0][15], 8'h00);
      chk("R7 B kept", wreg_q[1][4], 8'h14);
      chk("R7 B kept 15", wreg_q[1][15], 8'h01);
      chk("R7 shared kept", wreg_q[0][2], 8'h95);
      bus_rd(CHA, CTL, d);
      chk("R7 A pointer cleared", d, 8'hA1);
      reg_wr(CHA, 4'd9, 8'h80);
      chk("R6 rst_cmd B", {6'b0, rst_cmd}, 8'h02);
      chk("R7 B cleared", wreg_q[1][4], 8'h00);
   endtask

   task automatic t_full_reset;
      logic [7:0] d;
      reg_wr(CHA, 4'd12, 8'h11);
      reg_wr(CHB, 4'd12, 8'h22);
      set_ptr(CHB, 4'd13);
      reg_wr(CHA, 4'd9, 8'hFF);
      chk("R8 rst_cmd full", {6'b0, rst_cmd}, 8'h03);
      chk("R8 all cleared", {7'b0, |wreg_q}, 8'h00);
      bus_rd(CHB, CTL, d);
      chk("R8 B pointer cleared", d, 8'hB1);
   endtask

   task automatic t_simul;
      logic [7:0] d;
      bus_rd(CHA, DAT, d);
      chk("R14 prior read", d, 8'hA4);
      set_ptr(CHA, 4'd12);
      @(negedge clk);
      ch_sel = CHA; port_sel = CTL; wdata = 8'h66; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R14 read dropped", rdata, 8'hA4);
      chk("R14 write done", wreg_q[0][12], 8'h66);
      bus_rd(CHA, CTL, d);
      chk("R14 pointer returned", d, 8'hA1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      stat0_in    = {8'hB1, 8'hA1};
      stat1_in    = {8'hB2, 8'hA2};
      stat10_in   = {8'hB3, 8'hA3};
      rx_byte_in  = {8'hB4, 8'hA4};
      irq_pend_in = 6'b101101;
      vec_code_in = 3'b110;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pointer();
      t_wr0_cmd();
      t_alias();
      t_shared();
      t_irq();
      t_ext();
      t_pll();
      t_data();
      t_chan_reset();
      t_full_reset();
      t_simul();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule